// File: doc/BRIEF.md
# Signed BCD Add/Subtract Unit

This unit adds or subtracts two signed decimal words and returns a signed decimal word in the same format. A word is four BCD nibbles. The top nibble is a sign digit, 0 for positive and 1 for negative. The three nibbles below it hold the magnitude, from 0 to 999. The unit takes one operation per cycle and registers the result one cycle later. It has no handshake beyond a valid strobe in and a valid strobe out.

Inside, each negative term is turned into its nines complement and then brought to tens-complement form by an increment. The operand A gets its increment from a separate ripple. The operand B gets its increment as the carry-in of the main adder. The sign digit sums modulo 2. Each digit adder corrects a binary sum above 9 by adding 6 and passes a decimal carry upward.

A negative internal sum is converted back to sign plus magnitude before it leaves the unit. A result whose true magnitude exceeds 999 raises an overflow flag. The digits are still produced, from the wrapped internal sum, and are not corrected.

Top module: `bcd_addsub_unit`

## Requirements
- R1: Word format: bits [15:12] are the sign digit, [11:8] hundreds, [7:4] tens and [3:0] ones. On inputs a non-zero sign digit means negative. Stimulus uses only 0 and 1.
- R2: With op_sub = 0 the result equals A + B, evaluated as signed decimal values.
- R3: With op_sub = 1 the result equals A − B, evaluated as signed decimal values.
- R4: A zero result is always output as 0000, never as 1000. An input of 1000 (negative zero) acts as zero.
- R5: ovf is 1 exactly when the true result lies outside −999..+999.
- R6: Define t as the true result and s = t mod 2000, taken in 0..1999. The output is sign 0 with magnitude s when s < 1000. Otherwise it is sign 1 with magnitude (2000 − s) mod 1000. This rule also fixes the output when ovf is 1.
- R7: out_valid, res_word and ovf update on the clock edge after a cycle with in_valid = 1. out_valid is 0 after a cycle with in_valid = 0, and res_word and ovf then hold their values.
- R8: While rst is high, out_valid, res_word and ovf are 0 after the clock edge.
- R9: Every output digit is a valid BCD value (0..9), and the sign digit is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and op_sub are valid this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract B from A |
| a_word | input | 16 | Operand A, sign digit plus three BCD digits |
| b_word | input | 16 | Operand B, sign digit plus three BCD digits |
| out_valid | output | 1 | res_word and ovf hold a new result |
| res_word | output | 16 | Signed BCD result |
| ovf | output | 1 | True result magnitude exceeds 999 |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing and the hold of idle outputs;
- BCD-legal output digits;
- the absence of a negative-zero result;
- a few algebraic identities: adding zero returns A, subtracting a word from itself gives zero, and mixed-sign addition cannot overflow.

The actual decimal sums and differences need the bench's scenarios. So do the carry chains across all three digits, the wrapped digits produced on overflow in both directions, and the −1000 edge. There the bench's integer model gives the expected word.

// File: rtl/bcd_arith_pkg.sv
package bcd_arith_pkg;

    typedef logic [3:0] bcd_t;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } arith_op_t;

    typedef struct packed {
        logic carry;
        bcd_t digit;
    } digit_sum_t;

    function automatic bcd_t nines_of(input bcd_t d);
        return 4'd9 - d;
    endfunction

    function automatic digit_sum_t bcd_digit_sum(input bcd_t x, input bcd_t y, input logic ci);
        logic [4:0] raw;
        logic [4:0] fixed;
        digit_sum_t r;
        raw = {1'b0, x} + {1'b0, y} + {4'b0, ci};
        if (raw > 5'd9) begin
            fixed   = raw + 5'd6;
            r.digit = fixed[3:0];
            r.carry = 1'b1;
        end else begin
            r.digit = raw[3:0];
            r.carry = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
    import bcd_arith_pkg::*;
(
    input  bcd_t x,
    input  bcd_t y,
    input  logic ci,
    output bcd_t s,
    output logic co
);
    digit_sum_t r;

    assign r  = bcd_digit_sum(x, y, ci);
    assign s  = r.digit;
    assign co = r.carry;
endmodule

// File: rtl/bcd_ripple.sv
module bcd_ripple #(
    parameter int NUM_DIGITS = 3,
    localparam int MW = 4 * NUM_DIGITS
) (
    input  logic [MW-1:0] x,
    input  logic [MW-1:0] y,
    input  logic          ci,
    output logic [MW-1:0] s,
    output logic          co
);
    logic [NUM_DIGITS:0] c;

    assign c[0] = ci;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        bcd_digit_cell u_cell (
            .x  (x[4*g +: 4]),
            .y  (y[4*g +: 4]),
            .ci (c[g]),
            .s  (s[4*g +: 4]),
            .co (c[g+1])
        );
    end

    assign co = c[NUM_DIGITS];
endmodule

// File: rtl/bcd_nines_cmp.sv
module bcd_nines_cmp
    import bcd_arith_pkg::*;
#(
    parameter int NUM_DIGITS = 3,
    localparam int MW = 4 * NUM_DIGITS
) (
    input  logic [MW-1:0] d,
    input  logic          en,
    output logic [MW-1:0] q
);
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        assign q[4*g +: 4] = en ? nines_of(d[4*g +: 4]) : d[4*g +: 4];
    end
endmodule

// File: rtl/bcd_addsub_unit.sv
module bcd_addsub_unit
    import bcd_arith_pkg::*;
#(
    parameter int NUM_DIGITS = 3,
    localparam int MW = 4 * NUM_DIGITS,
    localparam int W  = MW + 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         op_sub,
    input  logic [W-1:0] a_word,
    input  logic [W-1:0] b_word,
    output logic         out_valid,
    output logic [W-1:0] res_word,
    output logic         ovf
);
    arith_op_t op;
    assign op = arith_op_t'(op_sub);

    // Operand A: nines complement plus one gives tens-complement form
    logic          a_neg;
    logic [MW-1:0] a_nc, a_tc;
    logic          a_co, a_tsign;

    assign a_neg = |a_word[W-1:MW];

    bcd_nines_cmp #(.NUM_DIGITS(NUM_DIGITS)) u_cmp_a (
        .d (a_word[MW-1:0]), .en (a_neg), .q (a_nc)
    );

    bcd_ripple #(.NUM_DIGITS(NUM_DIGITS)) u_inc_a (
        .x (a_nc), .y ('0), .ci (a_neg), .s (a_tc), .co (a_co)
    );

    assign a_tsign = a_neg ^ a_co;   // sign digit wraps modulo 2

    // Operand B: nines complement only, its +1 is the main carry-in
    logic          b_neg, b_eff_neg;
    logic [MW-1:0] b_nc;

    assign b_neg     = (|b_word[W-1:MW]) ^ (op == OP_SUB);
    assign b_eff_neg = b_neg & (|b_word[MW-1:0]);

    bcd_nines_cmp #(.NUM_DIGITS(NUM_DIGITS)) u_cmp_b (
        .d (b_word[MW-1:0]), .en (b_neg), .q (b_nc)
    );

    // Main decimal adder
    logic [MW-1:0] sum_d;
    logic          sum_co, sum_sign;

    bcd_ripple #(.NUM_DIGITS(NUM_DIGITS)) u_main (
        .x (a_tc), .y (b_nc), .ci (b_neg), .s (sum_d), .co (sum_co)
    );

    assign sum_sign = a_tsign ^ b_neg ^ sum_co;

    // Back to sign plus magnitude
    logic [MW-1:0] sum_nc, mag_out;
    logic          mag_co, neg_full;

    bcd_nines_cmp #(.NUM_DIGITS(NUM_DIGITS)) u_cmp_r (
        .d (sum_d), .en (sum_sign), .q (sum_nc)
    );

    bcd_ripple #(.NUM_DIGITS(NUM_DIGITS)) u_inc_r (
        .x (sum_nc), .y ('0), .ci (sum_sign), .s (mag_out), .co (mag_co)
    );

    // Internal value of exactly minus 10^N has no magnitude in N digits
    assign neg_full = sum_sign & mag_co;

    logic ovf_c;
    assign ovf_c = ((a_tsign == b_eff_neg) && (sum_sign != a_tsign)) || neg_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_word  <= '0;
            ovf       <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_word <= {3'b000, sum_sign, mag_out};
                ovf      <= ovf_c;
            end
        end
    end
endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk #(
    parameter int NUM_DIGITS = 3,
    localparam int MW = 4 * NUM_DIGITS,
    localparam int W  = MW + 4
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         op_sub,
    input logic [W-1:0] a_word,
    input logic [W-1:0] b_word,
    input logic         out_valid,
    input logic [W-1:0] res_word,
    input logic         ovf
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R7
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(res_word) && $stable(ovf))); // R7
    AST_SIGN_DIGIT: assert property (@(posedge clk) disable iff (rst) res_word[W-1:MW+1] == '0); // R9
    AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (rst) (out_valid && !ovf) |-> (res_word != {4'b0001, {MW{1'b0}}})); // R4
    AST_ADD_ZERO: assert property (@(posedge clk) disable iff (rst) (in_valid && !op_sub && b_word == '0 && a_word[MW-1:0] != '0 && a_word[W-1:MW+1] == '0) |=> (res_word == $past(a_word) && !ovf)); // R2
    AST_SUB_SELF: assert property (@(posedge clk) disable iff (rst) (in_valid && op_sub && a_word == b_word) |=> (res_word == '0 && !ovf)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (in_valid && !op_sub && a_word[W-1:MW] == 4'd0 && b_word[W-1:MW] == 4'd1) |=> !ovf); // R5

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
        AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst) res_word[4*g +: 4] <= 4'd9); // R9
    end
endmodule

bind bcd_addsub_unit bcd_addsub_chk #(.NUM_DIGITS(NUM_DIGITS)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_sub    (op_sub),
    .a_word    (a_word),
    .b_word    (b_word),
    .out_valid (out_valid),
    .res_word  (res_word),
    .ovf       (ovf)
);

// File: tb/test_bcd_addsub_unit.sv
module test_bcd_addsub_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        op_sub = 1'b0;
    logic [15:0] a_word = '0;
    logic [15:0] b_word = '0;
    logic        out_valid;
    logic [15:0] res_word;
    logic        ovf;

    always #10 clk = ~clk;

    bcd_addsub_unit i_bcd_addsub_unit (
        .clk (clk), .rst (rst), .in_valid (in_valid), .op_sub (op_sub),
        .a_word (a_word), .b_word (b_word),
        .out_valid (out_valid), .res_word (res_word), .ovf (ovf)
    );

    typedef struct {
        logic [15:0] res;
        logic        ovf;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;
    logic [15:0] last_res;
    logic        last_ovf;

    function automatic logic [15:0] enc(input bit s, input int m);
        logic [3:0] h, t, o;
        h = 4'(m / 100);
        t = 4'((m / 10) % 10);
        o = 4'(m % 10);
        return {3'b000, s, h, t, o};
    endfunction

    // R6 rule: s = t mod 2000, sign-magnitude back conversion
    function automatic exp_t model(input bit sa, input int ma, input bit sb, input int mb,
                                   input bit sub, input string tag);
        exp_t e;
        int va, vb, t, s;
        va = sa ? -ma : ma;
        vb = sb ? -mb : mb;
        t  = sub ? va - vb : va + vb;
        s  = ((t % 2000) + 2000) % 2000;
        e.res = (s < 1000) ? enc(0, s) : enc(1, (2000 - s) % 1000);
        e.ovf = (t > 999) || (t < -999);
        e.tag = tag;
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send(input bit sa, input int ma, input bit sb, input int mb,
                        input bit sub, input string tag);
        @(negedge clk);
        a_word   = enc(sa, ma);
        b_word   = enc(sb, mb);
        op_sub   = sub;
        in_valid = 1'b1;
        q.push_back(model(sa, ma, sb, mb, sub, tag));
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pop the scoreboard as results appear
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R7", "unexpected out_valid", 17'(out_valid), 17'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check({ovf, res_word} === {e.ovf, e.res}, e.tag, "result {ovf,res}",
                      {ovf, res_word}, {e.ovf, e.res});
                last_res = e.res;
                last_ovf = e.ovf;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        check(out_valid == 1'b0 && res_word == '0 && ovf == 1'b0, "R8", "reset state",
              {ovf, res_word}, 17'h0);
        rst = 1'b0;

        // R2 plain additions with carries
        send(0, 123, 0, 456, 0, "R2");
        send(0, 0,   0, 0,   0, "R2");
        send(0, 999, 0, 0,   0, "R2");
        send(0, 455, 0, 545, 0, "R2");
        send(0, 500, 0, 499, 0, "R2");
        // R3 subtraction, including the 500 - 155 case
        send(0, 500, 0, 155, 1, "R3");
        send(0, 155, 0, 500, 1, "R3");
        send(0, 5,   0, 5,   1, "R3");
        send(1, 500, 0, 499, 1, "R3");
        // R1 sign digit handling
        send(1, 1,   0, 3,   0, "R1");
        send(1, 200, 1, 300, 0, "R1");
        send(1, 7,   1, 7,   1, "R1");
        send(1, 999, 0, 0,   0, "R1");
        // R4 negative zero in and out
        send(1, 0,   1, 0,   0, "R4");
        send(1, 0,   0, 0,   1, "R4");
        send(0, 0,   0, 0,   1, "R4");
        send(1, 42,  0, 42,  0, "R4");
        // R5/R6 overflow in both directions and wrapped digits
        send(0, 999, 0, 1,   0, "R5/R6");
        send(0, 999, 0, 999, 0, "R5/R6");
        send(1, 500, 1, 500, 0, "R5/R6");
        send(1, 999, 0, 999, 1, "R5/R6");
        send(0, 999, 1, 1,   1, "R5/R6");
        idle(1);
        @(negedge clk);
        check(q.size() == 0, "R7", "latency drain", 17'(q.size()), 17'h0);

        // R7 hold while idle
        idle(4);
        check(out_valid == 1'b0 && res_word == last_res && ovf == last_ovf, "R7",
              "hold when idle", {ovf, res_word}, {last_ovf, last_res});

        // Mixed patterns, R9 validity covered by exact compare
        for (int i = 0; i < 300; i++) begin
            bit sa, sb, sub;
            int ma, mb;
            sa  = 1'($urandom_range(0, 1));
            sb  = 1'($urandom_range(0, 1));
            sub = 1'($urandom_range(0, 1));
            ma  = int'($urandom_range(0, 999));
            mb  = int'($urandom_range(0, 999));
            send(sa, ma, sb, mb, sub, sub ? "R3/R9" : "R2/R9");
            if (i % 7 == 3) idle(2);
        end
        idle(2);
        @(negedge clk);
        check(q.size() == 0, "R7", "final drain", 17'(q.size()), 17'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R7 watchdog: actual %0d expected %0d", q.size(), 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule